// File: doc/BRIEF.md
# Serial Payload Source for a Framed Line Transmitter

This block sits on the terminal-equipment side of a framed serial link. The downstream framer owns the bit clock, which nominally runs at 34.368 MHz. The block shifts payload onto the framer's serial data input, one bit per clock, and updates that bit on the rising edge. Payload arrives as bytes over a valid/ready stream, and each byte is sent most significant bit first.

The framer drives two plain control pins:
- `eof_i` pulses while the framer handles the last bit of a frame. The bit the source presents on that edge is the first bit of the next frame, and it is always the top bit of a freshly fetched byte. Any bits left over from the previous byte are dropped.
- `oh_i` pulses one clock ahead of an overhead slot. On that edge the source holds its output bit, so the next payload bit goes out one clock later.

Until the first `eof_i` after reset, the source outputs zeros and consumes nothing. When a byte is needed and none is offered, the source sends an all-ones idle byte and flags an underrun.

The source counts the payload bits it sends in each frame. At every end-of-frame pulse after the first, it compares that count with `FRAME_BITS` (1524 by default) and flags any mismatch.

Back-pressure rules for the byte stream:
- A byte is taken on a rising edge where `s_valid` and `s_ready` are both high.
- `s_ready` depends combinationally on `eof_i` and `oh_i`. It rises only on a clock whose edge will present the first bit of a new byte.
- While `s_ready` is low, the upstream may change `s_data` freely, and nothing is lost.

Top module: `payload_serial_src`

## Requirements
- R1: From reset until the first rising edge that samples `eof_i` high, `ser_o` stays 0 and `s_ready` stays 0, unless `eof_i` is high in the current cycle.
- R2: Bytes are serialised MSB first, one bit per non-stalled edge. `s_ready` is high only when the previous byte's bits have all been presented, or when `eof_i` is high.
- R3: On an edge that samples `oh_i` high, `ser_o` keeps its value, `s_ready` is 0 in that cycle, and nothing is consumed.
- R4: On an edge that samples `eof_i` high (and `oh_i` low), `ser_o` takes bit 7 of a newly fetched byte. Any unsent bits of the earlier byte are discarded.
- R5: When a fetch finds `s_valid` low, the byte 0xFF is sent in its place, and `underrun_o` is high for exactly the one cycle after that edge.
- R6: At each `eof_i` edge after the first, `frame_err_o` is high for one cycle if the number of bits presented since the previous `eof_i` edge (that edge included) differs from `FRAME_BITS`. Otherwise it stays 0.
- R7: While `rst_n` is low, `ser_o`, `underrun_o` and `frame_err_o` are 0.
- R8: A byte is accepted only on an edge where `s_valid` and `s_ready` are both high. `s_data` offered while `s_ready` is low is neither sent nor lost.
- R9: When `eof_i` and `oh_i` are sampled high together, the frame restarts but the output holds for that edge. The new byte is fetched on the next non-stalled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock supplied by the framer |
| rst_n | input | 1 | Active-low synchronous reset |
| eof_i | input | 1 | End-of-frame pulse from the framer |
| oh_i | input | 1 | Overhead look-ahead pulse |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte is offered |
| s_ready | output | 1 | Source takes the byte on this edge |
| ser_o | output | 1 | Serial payload bit to the framer |
| underrun_o | output | 1 | Idle byte was substituted |
| frame_err_o | output | 1 | Payload bit count per frame was wrong |

## Verification
The bench compares the block against a bit-queue model on every clock. It targets four situations:
- Overhead pulses that land mid-byte and on frame boundaries. A design that advanced through them would shift every later bit by one.
- End-of-frame pulses that arrive mid-byte. A design that kept the leftover bits would start the frame on the wrong bit.
- Gaps in `s_valid` at fetch time. A design that stalled or re-sent old data instead of sending 0xFF would show up here.
- One short frame and one long frame, each of which must raise `frame_err_o` exactly once. A coinciding end-of-frame and overhead pulse checks that the restart and the hold are applied together.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef struct packed {
    logic live;     // armed, or arming on this edge
    logic advance;  // a new bit is presented on this edge
    logic restart;  // frame boundary on this edge
  } step_t;
endpackage

// File: rtl/pss_frame_ctl.sv
module pss_frame_ctl
  import pss_pkg::*;
#(
  parameter int FRAME_BITS = 1524
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  eof_i,
  input  logic  oh_i,
  output step_t step,
  output logic  frame_err_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_GOAL = CNT_W'(FRAME_BITS);

  logic             armed;
  logic [CNT_W-1:0] bits_sent;

  always_comb begin
    step.live    = armed | eof_i;
    step.advance = (armed | eof_i) & ~oh_i;
    step.restart = eof_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      bits_sent   <= '0;
      frame_err_o <= 1'b0;
    end else if (eof_i) begin
      armed       <= 1'b1;
      frame_err_o <= armed && (bits_sent != CNT_GOAL);
      bits_sent   <= oh_i ? '0 : CNT_W'(1);
    end else begin
      frame_err_o <= 1'b0;
      if (step.advance && bits_sent != CNT_MAX) bits_sent <= bits_sent + 1'b1;
    end
  end
endmodule

// File: rtl/pss_serializer.sv
module pss_serializer
  import pss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_t             step,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              ser_o,
  output logic              underrun_o
);
  localparam int LEFT_W = $clog2(DATA_W + 1);
  localparam logic [DATA_W-1:0] IDLE = '1;

  logic [DATA_W-1:0] shreg;
  logic [LEFT_W-1:0] left;
  logic              need;
  logic [DATA_W-1:0] fresh;

  assign need    = (left == '0) || step.restart;
  assign s_ready = step.advance && need;
  assign fresh   = s_valid ? s_data : IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      left       <= '0;
      ser_o      <= 1'b0;
      underrun_o <= 1'b0;
    end else if (step.advance) begin
      if (need) begin
        ser_o      <= fresh[DATA_W-1];
        shreg      <= fresh << 1;
        left       <= LEFT_W'(DATA_W - 1);
        underrun_o <= ~s_valid;
      end else begin
        ser_o      <= shreg[DATA_W-1];
        shreg      <= shreg << 1;
        left       <= left - 1'b1;
        underrun_o <= 1'b0;
      end
    end else begin
      underrun_o <= 1'b0;
      if (step.restart) left <= '0;
    end
  end
endmodule

// File: rtl/payload_serial_src.sv
module payload_serial_src
  import pss_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FRAME_BITS = 1524
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eof_i,
  input  logic              oh_i,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              ser_o,
  output logic              underrun_o,
  output logic              frame_err_o
);
  step_t step;

  pss_frame_ctl #(.FRAME_BITS(FRAME_BITS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .eof_i(eof_i), .oh_i(oh_i),
    .step(step), .frame_err_o(frame_err_o)
  );

  pss_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .step(step),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .ser_o(ser_o), .underrun_o(underrun_o)
  );
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eof_i,
  input logic              oh_i,
  input logic [DATA_W-1:0] s_data,
  input logic              s_valid,
  input logic              s_ready,
  input logic              ser_o,
  input logic              underrun_o,
  input logic              frame_err_o
);
  logic seen_eof;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_eof <= 1'b0;
    else if (eof_i) seen_eof <= 1'b1;
  end

  // R1
  prearm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_eof && !eof_i) |-> (!s_ready && !ser_o));
  // R3
  oh_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oh_i |-> !s_ready);
  // R3
  oh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oh_i |=> $stable(ser_o));
  // R2
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid) |=> (ser_o == $past(s_data[DATA_W-1])));
  // R5
  idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> (ser_o && !$past(s_valid)));
  // R6
  err_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> $past(eof_i));
  // R5
  underrun_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> !underrun_o || $past(s_ready));
endmodule

bind payload_serial_src pss_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eof_i(eof_i), .oh_i(oh_i), .s_data(s_data),
  .s_valid(s_valid), .s_ready(s_ready), .ser_o(ser_o),
  .underrun_o(underrun_o), .frame_err_o(frame_err_o)
);

// File: tb/payload_serial_src_tb.sv
module payload_serial_src_tb;
  localparam int FB = 1524;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eof_d = 1'b0, oh_d = 1'b0, valid_d = 1'b0;
  logic [7:0] data_d = 8'h00;
  logic s_ready, ser_o, underrun_o, frame_err_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  payload_serial_src u_dut (
    .clk(clk), .rst_n(rst_n), .eof_i(eof_d), .oh_i(oh_d),
    .s_data(data_d), .s_valid(valid_d), .s_ready(s_ready),
    .ser_o(ser_o), .underrun_o(underrun_o), .frame_err_o(frame_err_o)
  );

  // reference model
  bit m_armed = 0, m_ser = 0, m_under = 0, m_ferr = 0;
  int m_cnt = 0, n_ferr = 0, n_under = 0;
  bit bitq[$];
  logic [7:0] src_byte = 8'h5A;
  string tag = "R7";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_ser = 0; m_under = 0; m_ferr = 0; m_cnt = 0;
      bitq.delete();
      tag = "R7";
    end else begin
      logic [7:0] b;
      m_under = 0; m_ferr = 0;
      tag = !m_armed && !eof_d ? "R1" : (eof_d && oh_d) ? "R9" :
            oh_d ? "R3" : eof_d ? "R4" : "R2";
      if (eof_d) begin
        m_ferr = m_armed && (m_cnt != FB);
        m_cnt = 0;
        bitq.delete();
      end
      if ((m_armed || eof_d) && !oh_d) begin
        if (bitq.size() == 0) begin
          if (valid_d) begin b = data_d; src_byte = src_byte * 8'd5 + 8'd23; end
          else begin b = 8'hFF; m_under = 1; end
          for (int i = 7; i >= 0; i--) bitq.push_back(b[i]);
        end
        m_ser = bitq.pop_front();
        m_cnt++;
      end
      if (eof_d) m_armed = 1;
      if (m_ferr) n_ferr++;
      if (m_under) n_under++;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(tag, ser_o, m_ser);
    chk("R8", s_ready, (m_armed || eof_d) && !oh_d && (bitq.size() == 0 || eof_d));
    chk("R5", underrun_o, m_under);
    chk("R6", frame_err_o, m_ferr);
  end

  task automatic finish_up();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int g_adv, target, frame;
    bit started, gaps;
    repeat (4) @(posedge clk);
    #2;
    // R7 reset state
    chk("R7", ser_o, 1'b0);
    chk("R7", underrun_o, 1'b0);
    chk("R7", frame_err_o, 1'b0);
    rst_n = 1'b1;
    started = 0; g_adv = 0; frame = 0; target = FB; gaps = 0;
    // R1: no eof for a while, random overhead and valid
    for (int c = 0; c < 40; c++) begin
      @(posedge clk); #2;
      oh_d = ($urandom % 5) == 0;
      valid_d = 1'b1; data_d = src_byte;
    end
    @(posedge clk); #2;
    eof_d = 1'b1; oh_d = 1'b0; data_d = src_byte;
    started = 1;
    while (frame < 7) begin
      @(posedge clk);
      if (eof_d) g_adv = oh_d ? 0 : 1;
      else if (!oh_d) g_adv++;
      if (eof_d && started) begin
        frame++;
        target = (frame == 3) ? FB - 5 : (frame == 5) ? FB + 2 : FB;
        gaps = (frame == 4 || frame == 5);
      end
      #2;
      eof_d = (g_adv == target) || (g_adv == target - 1 && ($urandom % 3) == 0 && 0);
      if (g_adv == target) begin
        eof_d = 1'b1;
        oh_d = frame[0];           // R9: coincident pulses on odd frames
      end else begin
        eof_d = 1'b0;
        oh_d = ($urandom % 13) == 0;
        if (g_adv == target - 1) oh_d = 1'b0; // land eof exactly on target
      end
      valid_d = gaps ? (($urandom % 6) != 0) : 1'b1;
      data_d = valid_d ? src_byte : 8'hC3;
    end
    repeat (3) @(posedge clk);
    #3;
    // R6: frames 3 (short) and 5 (long) must each flag once
    tests++;
    if (n_ferr != 2) begin
      fails++;
      $display("FAIL R6: actual %0d error pulses expected 2", n_ferr);
    end
    // R5: gaps must have produced underruns
    tests++;
    if (n_under == 0) begin
      fails++;
      $display("FAIL R5: actual 0 underruns expected >0");
    end
    finish_up();
  end
endmodule